// File: doc/BRIEF.md
# Doorbell-Advanced Buffer Remapper

This block lets a small, fixed window of bus address space stand in for a long sequence of buffers held in a much larger local address space. Local logic pushes page-aligned buffer base addresses into a queue. The oldest queued entry backs the window. Every access that lands in the window is translated into that buffer's base plus the access's offset within the window. The translated access comes out one cycle later, together with an ordering hint.

A remote agent writes to a single doorbell address to retire the current buffer. The next queued buffer then backs the window. Status flags report a full queue, an empty queue, a window access made with nothing queued, and a doorbell rung with nothing queued. The last of these is sticky.

Top module: `scatter_remap`

## Requirements
- R1: After reset, `q_empty` is 1, and `q_full`, `push_ack`, `push_nak`, `xl_valid`, `xl_underrun` and `db_err` are all 0.
- R2: A push with `push_addr[11:0]==0` is accepted while the queue holds fewer than DEPTH (16) entries: `push_ack` pulses one cycle later and the address joins the tail of the queue.
- R3: A push with any nonzero bit in `push_addr[11:0]` is refused: `push_nak` pulses one cycle later and the queue is unchanged.
- R4: `q_full` is 1 exactly when 16 entries are queued, and `q_empty` exactly when none are. A push while `q_full` is 1 is refused with `push_nak`, even if a doorbell pops in the same cycle.
- R5: A bus access hits the window when `bus_addr[19:16]==0`. A hit with a non-empty queue gives, one cycle later, `xl_valid`=1 and `xl_addr` = head entry + `bus_addr[15:0]`, with `xl_write` copying `bus_write`.
- R6: A bus write to `bus_addr==20'hF0000` (the doorbell) with a non-empty queue removes the head entry. Buffers back the window in the order they were pushed.
- R7: A doorbell write while the queue is empty changes nothing in the queue and sets `db_err` one cycle later. `db_err` stays 1 until reset.
- R8: A window hit while the queue is empty gives `xl_underrun`=1 and `xl_valid`=0 one cycle later.
- R9: The ordering mode `ord_mode` selects when `xl_fence` is 1:
  - 0 (unordered): reads only.
  - 1 (strict): always.
  - 2 (follow the packet): reads, and writes whose `bus_relaxed` is 0.
  - 3: treated as 1.
- R10: A bus access that hits neither the window nor the doorbell, or a read of the doorbell, produces no translation, no underrun, no error and no change to the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Local side offers a buffer address |
| push_addr | input | 40 | Buffer base address, must be 4 KiB aligned |
| push_ack | output | 1 | Previous cycle's push was queued |
| push_nak | output | 1 | Previous cycle's push was refused |
| bus_valid | input | 1 | Remote access present |
| bus_write | input | 1 | Remote access is a write |
| bus_relaxed | input | 1 | Remote access carries relaxed ordering |
| bus_addr | input | 20 | Remote access address |
| ord_mode | input | 2 | Ordering mode of the region |
| xl_valid | output | 1 | Translated access present |
| xl_addr | output | 40 | Translated local address |
| xl_write | output | 1 | Translated access is a write |
| xl_fence | output | 1 | Translated access must wait for earlier ones |
| xl_underrun | output | 1 | Window access found the queue empty |
| db_err | output | 1 | Sticky: doorbell rung on an empty queue |
| q_full | output | 1 | Queue holds 16 entries |
| q_empty | output | 1 | Queue holds no entries |

## Verification
The bench targets the following corner cases. Each is listed with how a faulty design would misbehave.

- A push in the same cycle as a doorbell on a full queue: a design that nets the two together would wrongly accept the push.
- A doorbell on an empty queue: a design that decrements anyway would wrap its count and report a full queue of stale buffers.
- A push into an empty queue followed directly by a window access: a design that reads the wrong head pointer would translate with an old buffer.
- Misaligned pushes: a design that only checks bit 0 would queue them.
- Reads and writes under all four ordering modes with both relaxed values: a design that inverts the relaxed bit or mishandles mode 3 would give a wrong fence.
- Doorbell reads and accesses outside both decodes: a design that decodes them loosely would pop buffers on reads.

// File: rtl/scatter_remap.sv
module scatter_remap #(
  parameter int ADDR_W    = 40,
  parameter int BUS_W     = 20,
  parameter int WIN_BITS  = 16,
  parameter int PAGE_BITS = 12,
  parameter int DEPTH     = 16,
  parameter logic [BUS_W-1:0] WIN_BASE = 20'h00000,
  parameter logic [BUS_W-1:0] DB_ADDR  = 20'hF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  output logic              push_ack,
  output logic              push_nak,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_relaxed,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic [1:0]        ord_mode,
  output logic              xl_valid,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              xl_write,
  output logic              xl_fence,
  output logic              xl_underrun,
  output logic              db_err,
  output logic              q_full,
  output logic              q_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic fence_c;

  assign q_empty = (cnt == '0);
  assign q_full  = (cnt == CW'(DEPTH));

  wire aligned = (push_addr[PAGE_BITS-1:0] == '0);
  wire do_push = push_valid && aligned && !q_full;
  wire win_hit = bus_valid && (bus_addr[BUS_W-1:WIN_BITS] == WIN_BASE[BUS_W-1:WIN_BITS]);
  wire db_hit  = bus_valid && bus_write && (bus_addr == DB_ADDR);
  wire do_pop  = db_hit && !q_empty;

  always_comb begin
    case (ord_mode)
      2'd0:    fence_c = !bus_write;
      2'd2:    fence_c = !bus_write || !bus_relaxed;
      default: fence_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      push_ack <= 1'b0;
      push_nak <= 1'b0;
      xl_valid <= 1'b0;
      xl_addr <= '0;
      xl_write <= 1'b0;
      xl_fence <= 1'b0;
      xl_underrun <= 1'b0;
      db_err <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      push_ack <= do_push;
      push_nak <= push_valid && !do_push;
      xl_valid <= win_hit && !q_empty;
      xl_underrun <= win_hit && q_empty;
      if (win_hit && !q_empty) begin
        xl_addr  <= mem[rp] + ADDR_W'(bus_addr[WIN_BITS-1:0]);
        xl_write <= bus_write;
        xl_fence <= fence_c;
      end
      if (db_hit && q_empty) db_err <= 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> q_empty && !db_err && !xl_valid && !push_ack);

  assert_misaligned_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_addr[PAGE_BITS-1:0] != '0 |=> push_nak && !push_ack);

  assert_full_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && q_full |=> push_nak && !push_ack);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH) && !(q_full && q_empty));

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit && !q_empty |=> xl_valid && xl_addr[PAGE_BITS-1:0] == $past(bus_addr[PAGE_BITS-1:0]));

  assert_pop_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    db_hit && !q_empty && !push_valid |=> cnt == $past(cnt) - 1'b1);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);

  assert_empty_db_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    db_hit && q_empty && !push_valid |=> q_empty && db_err);

  assert_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit && q_empty |=> xl_underrun && !xl_valid);

  assert_strict_fence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit && !q_empty && ord_mode == 2'd1 |=> xl_fence);

  assert_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit && !db_hit |=> !xl_valid && !xl_underrun);
endmodule

// File: tb/sim_scatter_remap.sv
module sim_scatter_remap;
  localparam int PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [39:0] push_addr = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_relaxed = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [1:0] ord_mode = '0;
  logic push_ack, push_nak, xl_valid, xl_write, xl_fence, xl_underrun, db_err, q_full, q_empty;
  logic [39:0] xl_addr;

  scatter_remap u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_addr(push_addr),
    .push_ack(push_ack), .push_nak(push_nak), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_relaxed(bus_relaxed), .bus_addr(bus_addr), .ord_mode(ord_mode),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_write(xl_write), .xl_fence(xl_fence),
    .xl_underrun(xl_underrun), .db_err(db_err), .q_full(q_full), .q_empty(q_empty));

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [39:0] q[$];
  logic e_ack = 0, e_nak = 0, e_xv = 0, e_xw = 0, e_fence = 0, e_under = 0, e_err = 0;
  logic [39:0] e_xa = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2 push_ack", 64'(push_ack), 64'(e_ack));
    check("R3 push_nak", 64'(push_nak), 64'(e_nak));
    check("R4 q_full", 64'(q_full), 64'(q.size() == DEPTH));
    check("R4 q_empty", 64'(q_empty), 64'(q.size() == 0));
    check("R5 xl_valid", 64'(xl_valid), 64'(e_xv));
    check("R8 xl_underrun", 64'(xl_underrun), 64'(e_under));
    check("R7 db_err", 64'(db_err), 64'(e_err));
    if (e_xv) begin
      check("R5 xl_addr", 64'(xl_addr), 64'(e_xa));
      check("R5 xl_write", 64'(xl_write), 64'(e_xw));
      check("R9 xl_fence", 64'(xl_fence), 64'(e_fence));
    end
  endtask

  // one cycle: compare previous results, drive new stimulus, advance the model
  task automatic step(input logic pv, input logic [39:0] pa, input logic bv, input logic bw,
                      input logic [19:0] ba, input logic rel, input logic [1:0] md);
    logic win, db;
    @(negedge clk);
    compare_all();
    push_valid = pv; push_addr = pa; bus_valid = bv; bus_write = bw;
    bus_addr = ba; bus_relaxed = rel; ord_mode = md;
    win = bv && ba[19:16] == 4'h0;
    db = bv && bw && ba == 20'hF0000;
    e_ack = pv && pa[11:0] == 12'h0 && q.size() < DEPTH;
    e_nak = pv && !e_ack;
    e_xv = win && q.size() > 0;
    e_under = win && q.size() == 0;
    if (e_xv) begin
      e_xa = q[0] + {24'h0, ba[15:0]};
      e_xw = bw;
      case (md)
        2'd0: e_fence = !bw;
        2'd2: e_fence = !bw || !rel;
        default: e_fence = 1'b1;
      endcase
    end
    if (db && q.size() == 0) e_err = 1'b1;
    if (db && q.size() > 0) void'(q.pop_front());
    if (e_ack) q.push_back(pa);
  endtask

  function automatic logic [39:0] page(input int n);
    return {8'h0, 20'h12345 + 20'(n * 7), 12'h000};
  endfunction

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    check("R1 q_empty", 64'(q_empty), 64'd1);
    check("R1 q_full", 64'(q_full), 64'd0);
    check("R1 xl_valid", 64'(xl_valid), 64'd0);
    check("R1 db_err", 64'(db_err), 64'd0);
    // R8 underrun, R10 ignored, R7 empty doorbell
    step(0, 0, 1, 0, 20'h00100, 0, 0);
    step(0, 0, 1, 1, 20'h80000, 0, 0);
    step(0, 0, 1, 0, 20'hF0000, 0, 0);
    step(0, 0, 1, 1, 20'hF0000, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R3 misaligned, R2 push then immediate access
    step(1, 40'h00_0001_0800, 0, 0, 0, 0, 0);
    step(1, page(0), 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 20'h0ABCD, 0, 0);
    // R4 fill to full and overfill, including push with doorbell on full
    for (int i = 1; i < 20; i++) step(1, page(i), 1, 0, 20'(i * 333), 0, 2'(i));
    step(1, page(50), 1, 1, 20'hF0000, 0, 0);
    step(1, page(51), 0, 0, 0, 0, 0);
    // R9 all modes, R6 drain in order
    for (int i = 0; i < 20; i++) begin
      step(0, 0, 1, i[0], 20'(i * 1111), i[1], 2'(i >> 2));
      step(0, 0, 1, 1, 20'hF0000, 0, 0);
      step(0, 0, 1, 0, 20'hF0000, 0, 0);
    end
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      int bias = (i / 500) % 2 == 0 ? 60 : 25;
      logic [39:0] pa = {$urandom, $urandom};
      logic [19:0] ba;
      if ($urandom_range(0, 9) < 8) pa[11:0] = 12'h0;
      if (r < 55) ba = {4'h0, 16'($urandom)};
      else if (r < 80) ba = 20'hF0000;
      else ba = 20'($urandom) | 20'h10000;
      step(int'($urandom_range(0, 99)) < bias, pa, $urandom_range(0, 3) != 0,
           1'($urandom), ba, 1'($urandom), 2'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule